// File: doc/BRIEF.md
# Johnson-Code Seven-Segment Decoder with Display Gate

This block turns the five-bit state of a Johnson (twisted-ring) decade counter straight into active-high drive for a seven-segment digit, with no binary or BCD step in between. It is purely combinational: any change on the state or enable inputs reaches the outputs without a clock.

A display-gate input forces all seven segment outputs low, so a digit can be dark to save power or time-shared in a multiplexed display. The gate is passed out again unchanged for the next stage. A copy of the c segment bypasses the gate and stays valid at all times, so divider logic built around the counter can use it whatever the display is doing. Any state a decade Johnson counter never enters decodes to a dark digit.

Top module: `jc7_decoder_top`

## Requirements
- R1: The legal states on `jstate_i` decode to digits 0 to 9 in this order: 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000. Each new state shifts left and takes the inverse of bit 4 into bit 0.
- R2: `seg_o` bit 0 drives segment a, and bits 1 to 6 drive b, c, d, e, f and g. A bit is 1 when its segment is lit. With the gate open, digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R3: Digit 6 lights segment a, and digit 9 lights segment d. Both tails are present in the default build.
- R4: Every other five-bit value on `jstate_i` gives `seg_o` = 0 and `seg_c_raw_o` = 0, whatever the state of the gate.
- R5: When `disp_on_i` is 0, `seg_o` is 0 for every state.
- R6: `seg_c_raw_o` is 1 exactly for digits other than 2, and it does not depend on `disp_on_i`.
- R7: `disp_on_o` equals `disp_on_i` at all times.
- R8: All outputs follow their inputs without a clock edge, and a change of the gate alone changes `seg_o` straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| jstate_i | input | 5 | Johnson counter state |
| disp_on_i | input | 1 | Display gate; 1 lets the segments through |
| seg_o | output | 7 | Gated segments, bit 0 = a through bit 6 = g |
| seg_c_raw_o | output | 1 | Ungated c segment |
| disp_on_o | output | 1 | Copy of the display gate |

## Verification
The bench goes after the states next to the wrap point (11111, 10000 and 00000). A decoder with a wrong match pattern would light the wrong digit there or leave it dark. Illegal codes with more than one transition, such as 01010 and 10101, must stay dark; a decoder that reads only a few bits, as simple Johnson decoders do, would light a digit for them. The bench toggles the gate with the state held, to catch an ungated c copy that wrongly follows the gate and a gate that leaks segments. Digits 6 and 9 are checked for their tails, since a common table slip drops segment a or d.

// File: rtl/jc7_pkg.sv
package jc7_pkg;
   localparam int unsigned SEG_N   = 7;
   localparam int unsigned DIGIT_W = 4;
   localparam int unsigned SEG_A   = 0;
   localparam int unsigned SEG_C   = 2;
   localparam int unsigned SEG_D   = 3;
   typedef logic [DIGIT_W-1:0] digit_t;
   typedef logic [SEG_N-1:0]   seg_t;
endpackage

// File: rtl/jc7_state_decode.sv
module jc7_state_decode
   import jc7_pkg::*;
#(
   parameter int unsigned JW = 5
) (
   input  logic [JW-1:0] state_i,
   output digit_t        digit_o,
   output logic          valid_o
);
   localparam int unsigned NS = 2 * JW;

   if (NS > (1 << DIGIT_W)) begin : g_bad_width
      $error("jc7_state_decode: too many states for digit width");
   end

   logic [NS-1:0] hit;

   for (genvar k = 0; k < NS; k++) begin : g_match
      if (k < JW) begin : g_fill
         localparam logic [JW-1:0] PAT = (JW'(1) << k) - JW'(1);
         assign hit[k] = (state_i == PAT);
      end else begin : g_drain
         localparam logic [JW-1:0] PAT = ~((JW'(1) << (k - JW)) - JW'(1));
         assign hit[k] = (state_i == PAT);
      end
   end

   always_comb begin
      digit_o = '0;
      for (int i = 0; i < NS; i++) begin
         if (hit[i]) digit_o = DIGIT_W'(i);
      end
      valid_o = |hit;
   end

   always_comb begin
      if (!$isunknown(state_i)) begin
         a_r1_single_match: assert ($onehot0(hit))
            else $error("R1: more than one Johnson pattern matched");
      end
   end
endmodule

// File: rtl/jc7_digit_seg.sv
module jc7_digit_seg
   import jc7_pkg::*;
#(
   parameter bit SIX_TAIL  = 1'b1,
   parameter bit NINE_TAIL = 1'b1
) (
   input  digit_t digit_i,
   input  logic   valid_i,
   output seg_t   seg_o
);
   seg_t six_pat;
   seg_t nine_pat;

   if (SIX_TAIL) begin : g_six_a
      assign six_pat = 7'h7D;
   end else begin : g_six_plain
      assign six_pat = 7'h7C;
   end

   if (NINE_TAIL) begin : g_nine_d
      assign nine_pat = 7'h6F;
   end else begin : g_nine_plain
      assign nine_pat = 7'h67;
   end

   always_comb begin
      seg_o = '0;
      if (valid_i) begin
         case (digit_i)
            4'd0: seg_o = 7'h3F;
            4'd1: seg_o = 7'h06;
            4'd2: seg_o = 7'h5B;
            4'd3: seg_o = 7'h4F;
            4'd4: seg_o = 7'h66;
            4'd5: seg_o = 7'h6D;
            4'd6: seg_o = six_pat;
            4'd7: seg_o = 7'h07;
            4'd8: seg_o = 7'h7F;
            4'd9: seg_o = nine_pat;
            default: seg_o = '0;
         endcase
      end
   end

   always_comb begin
      if (!$isunknown({valid_i, digit_i})) begin
         a_r4_dark_when_illegal: assert (valid_i || (seg_o == '0))
            else $error("R4: segments lit for illegal state");
         a_r3_tails: assert (!(valid_i && digit_i == 4'd6 && SIX_TAIL) || seg_o[SEG_A])
            else $error("R3: six lacks segment a");
      end
   end
endmodule

// File: rtl/jc7_seg_gate.sv
module jc7_seg_gate
   import jc7_pkg::*;
(
   input  seg_t raw_i,
   input  logic on_i,
   output seg_t seg_o
);
   assign seg_o = on_i ? raw_i : '0;
endmodule

// File: rtl/jc7_decoder_top.sv
module jc7_decoder_top
   import jc7_pkg::*;
#(
   parameter int unsigned JW        = 5,
   parameter bit          SIX_TAIL  = 1'b1,
   parameter bit          NINE_TAIL = 1'b1
) (
   input  logic [JW-1:0]    jstate_i,
   input  logic             disp_on_i,
   output logic [SEG_N-1:0] seg_o,
   output logic             seg_c_raw_o,
   output logic             disp_on_o
);
   if (JW != 5) begin : g_bad_jw
      $error("jc7_decoder_top: decimal segment table needs JW of 5");
   end

   digit_t digit;
   logic   valid;
   seg_t   raw;

   jc7_state_decode #(.JW(JW)) u_state (
      .state_i (jstate_i),
      .digit_o (digit),
      .valid_o (valid)
   );

   jc7_digit_seg #(.SIX_TAIL(SIX_TAIL), .NINE_TAIL(NINE_TAIL)) u_seg (
      .digit_i (digit),
      .valid_i (valid),
      .seg_o   (raw)
   );

   jc7_seg_gate u_gate (
      .raw_i (raw),
      .on_i  (disp_on_i),
      .seg_o (seg_o)
   );

   assign seg_c_raw_o = raw[SEG_C];
   assign disp_on_o   = disp_on_i;

   always_comb begin
      if (!$isunknown({jstate_i, disp_on_i})) begin
         a_r5_dark_when_off: assert (disp_on_i || (seg_o == '0))
            else $error("R5: segments lit while display is off");
         a_r6_raw_c_matches: assert (!disp_on_i || (seg_o[SEG_C] == seg_c_raw_o))
            else $error("R6: ungated c disagrees with gated c");
      end
   end
endmodule

// File: tb/sim_jc7_decoder_top.sv
module sim_jc7_decoder_top;
   logic       clk = 1'b0;
   logic [4:0] jst;
   logic       on;
   logic [6:0] seg;
   logic       craw;
   logic       on_o;
   int         checks = 0;
   int         errors = 0;

   always #5 clk = ~clk;

   jc7_decoder_top u0 (
      .jstate_i    (jst),
      .disp_on_i   (on),
      .seg_o       (seg),
      .seg_c_raw_o (craw),
      .disp_on_o   (on_o)
   );

   function automatic logic [4:0] jcode(input int d);
      logic [4:0] s = 5'b00000;
      for (int i = 0; i < d; i++) s = {s[3:0], ~s[4]};
      return s;
   endfunction

   function automatic logic [6:0] exp_seg(input int d);
      case (d)
         0: return 7'b0111111;
         1: return 7'b0000110;
         2: return 7'b1011011;
         3: return 7'b1001111;
         4: return 7'b1100110;
         5: return 7'b1101101;
         6: return 7'b1111101;
         7: return 7'b0000111;
         8: return 7'b1111111;
         9: return 7'b1101111;
         default: return 7'b0000000;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [4:0] s, input logic e);
      @(negedge clk);
      jst = s;
      on  = e;
      #2;
   endtask

   task automatic t_reset_dark();
      apply(5'b00000, 1'b0);
      chk("R5 start dark", int'(seg), 0);
      chk("R7 start gate copy", int'(on_o), 0);
   endtask

   task automatic t_digits_on();
      for (int d = 0; d < 10; d++) begin
         apply(jcode(d), 1'b1);
         chk("R1 R2 digit pattern", int'(seg), int'(exp_seg(d)));
         chk("R6 raw c lit", int'(craw), (d == 2) ? 0 : 1);
      end
      apply(jcode(6), 1'b1);
      chk("R3 six has a", int'(seg[0]), 1);
      apply(jcode(9), 1'b1);
      chk("R3 nine has d", int'(seg[3]), 1);
   endtask

   task automatic t_digits_off();
      for (int d = 0; d < 10; d++) begin
         apply(jcode(d), 1'b0);
         chk("R5 dark when off", int'(seg), 0);
         chk("R6 raw c ungated", int'(craw), (d == 2) ? 0 : 1);
         chk("R7 gate copy low", int'(on_o), 0);
      end
   endtask

   task automatic t_illegal();
      for (int v = 0; v < 32; v++) begin
         bit legal = 1'b0;
         for (int d = 0; d < 10; d++) if (jcode(d) == 5'(v)) legal = 1'b1;
         if (!legal) begin
            apply(5'(v), 1'b1);
            chk("R4 illegal dark", int'(seg), 0);
            chk("R4 illegal raw c", int'(craw), 0);
         end
      end
   endtask

   task automatic t_gate_toggle();
      apply(jcode(8), 1'b1);
      chk("R8 lit", int'(seg), 7'h7F);
      #1 on = 1'b0;
      #1;
      chk("R8 gate off no clock", int'(seg), 0);
      chk("R6 c stays", int'(craw), 1);
      chk("R7 gate copy follows", int'(on_o), 0);
      #1 on = 1'b1;
      #1;
      chk("R8 gate on no clock", int'(seg), 7'h7F);
      chk("R7 gate copy high", int'(on_o), 1);
   endtask

   initial begin
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      jst = 5'b00000;
      on  = 1'b0;
      t_reset_dark();
      t_digits_on();
      t_digits_off();
      t_illegal();
      t_gate_toggle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule